// File: doc/BRIEF.md
# MFM Write-Path Bit Encoder

This block turns a serial stream of data bits into a Modified Frequency Modulation code stream for the write side of a magnetic-media channel. Each data bit becomes two code bits. The first is the clock bit and the second is the data bit. The code stream therefore runs at twice the data rate: at a 500 kbit/s data rate the code stream is 1 Mbit/s.

The clock bit depends on history. For a data 1 it is always 0. For a data 0 it is the inverse of the code bit emitted just before it. The encoder keeps the last emitted code bit on its output and uses it as that history.

An upstream source offers bits through a valid/ready handshake. The encoder samples a bit only at the start of a pair. It then emits one code bit every `CODE_DIV` system clocks and marks each one with a single-cycle strobe. If no bit is offered when a pair is due, the encoder emits nothing, keeps its history and raises a one-cycle underrun flag.

Top module: `mfm_encoder`

## Requirements
- R1: An accepted data bit of 1 produces the code pair 0 (clock bit) then 1 (data bit).
- R2: An accepted data bit of 0 produces a clock bit equal to the inverse of the previous emitted code bit, followed by 0.
- R3: In each pair the clock bit is emitted first, and the data bit follows exactly `CODE_DIV` clocks later with a value equal to the accepted data bit.
- R4: `code_stb` is high for exactly one clock per emitted code bit, and consecutive code bits are at least `CODE_DIV` clocks apart, so the code rate is twice the data rate.
- R5: While and after reset, `code_stb`, `underrun` and `code_bit` are 0, so the stored previous code bit is 0 and a first data 0 encodes as 1 then 0.
- R6: `din_ready` is high only in the single clock that opens a clock-bit slot. At any other time `din` and `din_valid` have no effect on the emitted code.
- R7: If `din_valid` is low when a clock-bit slot opens, no code bit is emitted and `underrun` pulses for one clock. The previous code bit is kept, so the next pair is encoded from it. A stream with no gaps raises no underrun.
- R8: The emitted code never contains two adjacent 1 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_valid | input | 1 | A data bit is offered on `din` |
| din | input | 1 | Data bit to encode |
| din_ready | output | 1 | Encoder takes `din` in this clock if `din_valid` is high |
| code_bit | output | 1 | Current code bit; it holds the last emitted value between strobes |
| code_stb | output | 1 | One-clock pulse marking a new `code_bit` |
| underrun | output | 1 | One-clock pulse when a pair was due and no data was offered |

## Verification
The encoder is driven with several bit patterns, and each one separates a different case.
- A run of zeros shows that the clock bit alternates correctly.
- A run of ones shows that the clock bit is held at 0.
- Alternating and mixed sequences cover each transition of the previous code bit.
- A leading zero straight after reset, and again after a mid-stream reset that follows a one, exposes a wrong reset value of the history bit.
- Idle gaps between bursts test the underrun pulse and show that the history survives a stall.
- A driver puts garbage on `din` whenever the encoder is not ready, to check that nothing is sampled outside the clock-bit slot.

// File: rtl/mfm_encoder.sv
module mfm_encoder #(
  parameter int unsigned CODE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_valid,
  input  logic din,
  output logic din_ready,
  output logic code_bit,
  output logic code_stb,
  output logic underrun
);

  localparam int unsigned CW = (CODE_DIV > 1) ? $clog2(CODE_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CODE_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          in_pair_q;
  logic          data_q;

  wire slot = (cnt_q == LAST);
  assign din_ready = slot && !in_pair_q;
  wire take = din_ready && din_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      in_pair_q <= 1'b0;
      data_q    <= 1'b0;
      code_bit  <= 1'b0;
      code_stb  <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      cnt_q    <= slot ? '0 : cnt_q + 1'b1;
      code_stb <= take || (slot && in_pair_q);
      underrun <= din_ready && !din_valid;
      if (take) begin
        in_pair_q <= 1'b1;
        data_q    <= din;
        code_bit  <= din ? 1'b0 : ~code_bit;
      end else if (slot && in_pair_q) begin
        in_pair_q <= 1'b0;
        code_bit  <= data_q;
      end
    end
  end

  // R1 data one gives clock bit zero
  a_r1_one_clock_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (take && din) |=> (code_stb && !code_bit));

  // R2 data zero inverts history
  a_r2_zero_clock_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !din) |=> (code_stb && (code_bit != $past(code_bit))));

  // R3 data slot repeats the sampled bit
  a_r3_data_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && in_pair_q) |=> (code_stb && !in_pair_q));

  // R4 strobe lasts one clock
  a_r4_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    code_stb |=> !code_stb);

  // R6 ready only at an open clock-bit slot
  a_r6_ready_slot: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> (!in_pair_q && !code_stb));

  // R7 underrun emits nothing
  a_r7_underrun_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (!code_stb && $stable(code_bit) && !in_pair_q));

  // R8 no adjacent ones
  a_r8_no_double_one: assert property (@(posedge clk) disable iff (!rst_n)
    (code_stb && code_bit) |-> !$past(code_bit));

endmodule

// File: tb/sim_mfm_encoder.sv
module sim_mfm_encoder;
  localparam int CLK_NS = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din_valid = 1'b0;
  logic din = 1'b0;
  logic din_ready, code_bit, code_stb, underrun;

  mfm_encoder #(.CODE_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .din(din),
    .din_ready(din_ready), .code_bit(code_bit), .code_stb(code_stb),
    .underrun(underrun)
  );

  always #(CLK_NS/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int ur_cnt = 0;
  int last_stb = 0;
  bit mon_data = 1'b0;
  bit done = 1'b0;
  bit prev_model = 1'b0;
  bit exp_q[$];
  string tag_q[$];

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && underrun) ur_cnt++;
    if (rst_n && code_stb) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected strobe", 1, 0);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(code_bit == e, t, code_bit, e);
        if (mon_data) check(cyc - last_stb == DIV, "R3 pair spacing", cyc - last_stb, DIV);
        else check(cyc - last_stb >= DIV, "R4 slot spacing", cyc - last_stb, DIV);
        mon_data = ~mon_data;
      end
      last_stb = cyc;
    end
  end

  task automatic send(bit b, bit noisy);
    bit c;
    @(negedge clk);
    din_valid = 1'b1;
    din = noisy ? ~b : b;
    while (!din_ready) begin
      @(negedge clk);
      din = noisy ? ~din : b;
    end
    din = b;
    c = b ? 1'b0 : ~prev_model;
    exp_q.push_back(c);
    tag_q.push_back(b ? "R1 clock bit" : "R2 clock bit");
    exp_q.push_back(b);
    tag_q.push_back(b ? "R1 data bit" : "R3 data bit");
    prev_model = b;
    if (noisy) begin
      @(posedge clk);
      @(negedge clk);
      din = ~b;
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    din_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(logic [15:0] w, int n, bit noisy);
    for (int i = n - 1; i >= 0; i--) send(w[i], noisy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(code_stb == 0, "R5 reset strobe", code_stb, 0);
    check(underrun == 0, "R5 reset underrun", underrun, 0);
    check(code_bit == 0, "R5 reset code bit", code_bit, 0);
    rst_n = 1'b1;
    @(negedge clk);
    ur_cnt = 0;
    send(1'b0, 1'b0);
    send_word(16'h0000, 8, 1'b0);
    send_word(16'h00FF, 8, 1'b0);
    send_word(16'hAAAA, 16, 1'b0);
    send_word(16'h3669, 16, 1'b0);
    check(ur_cnt == 0, "R7 no underrun in stream", ur_cnt, 0);
    idle(6 * DIV);
    check(exp_q.size() == 0, "R4 drained", exp_q.size(), 0);
    check(ur_cnt >= 2, "R7 underrun during gap", ur_cnt, 2);
    send_word(16'h0004, 3, 1'b0);
    idle(5 * DIV);
    send_word(16'h0001, 2, 1'b0);
    send_word(16'hC5A3, 16, 1'b1);
    idle(4 * DIV);
    send(1'b1, 1'b0);
    idle(4 * DIV);
    check(exp_q.size() == 0, "R6 drained before reset", exp_q.size(), 0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(code_bit == 0, "R5 mid reset code bit", code_bit, 0);
    check(code_stb == 0, "R5 mid reset strobe", code_stb, 0);
    prev_model = 1'b0;
    mon_data = 1'b0;
    rst_n = 1'b1;
    send(1'b0, 1'b0);
    send(1'b0, 1'b0);
    idle(4 * DIV);
    check(exp_q.size() == 0, "R8 final drain", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule